// File: doc/BRIEF.md
# Fly-by DMA Transfer Controller

This block moves words from a peripheral into memory without the processor handling each word. Software programs a start address and a word count through a small write port. When the peripheral raises its request line, the controller asks the processor for the system bus. It waits for the processor to grant the bus. It then acknowledges the peripheral and runs one word per cycle. In each of those cycles it drives the memory address and raises the peripheral-read and memory-write strobes together. The data itself goes straight from the peripheral onto the memory bus and never passes through this block.

The peripheral request and acknowledge pair acts as the flow-control handshake of the stream. A word moves only in a cycle where acknowledge is high. The peripheral applies back-pressure by dropping its request. The word in flight at that edge still completes. After it the controller hands the bus back and keeps its address and remaining count, so a later request resumes where the stream stopped. When the count runs out, the bus is released and a one-cycle completion pulse is produced.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: After reset, `bus_hold`, `dev_ack`, `io_rd`, `mem_wr`, `mem_addr_oe` and `tc_done` are low and `mem_addr` is zero; the address and count registers are zero.
- R2: A transfer starts only from a high `dev_req` sampled while idle with a nonzero count. `bus_hold` rises in the next cycle. It stays high without a break until the transfer or the paused burst ends.
- R3: Until `hold_ack` has been sampled high while `bus_hold` is asserted, `dev_ack`, `mem_addr_oe` and both strobes stay low.
- R4: `dev_ack` rises in the cycle after the grant is sampled. It stays high through the last word, which gives exactly one more acknowledge cycle than words moved in a burst.
- R5: Each word takes one cycle in which `io_rd` and `mem_wr` are both high, `mem_addr_oe` is high and `mem_addr` carries the current address. Whenever `mem_addr_oe` is low, `mem_addr` reads zero.
- R6: After every word the address register increments by one and the count register decrements by one. Successive words therefore use consecutive addresses starting at the programmed value.
- R7: The controller releases the bus in the cycle after the word that brings the count to zero. In that cycle `bus_hold`, `dev_ack`, the strobes and `mem_addr_oe` are low, and `tc_done` is high for exactly that one cycle.
- R8: If `dev_req` is low at the edge that ends a word and words remain, that word still counts. The bus is released without `tc_done`. The next request resumes at the following address with the remaining count.
- R9: Once `bus_hold` falls, it stays low for at least one full cycle before it can rise again, even when `dev_req` stays high.
- R10: A write with `cfg_we` high loads the start address when `cfg_sel` is 0 and the word count when `cfg_sel` is 1. Such writes are ignored while `bus_hold` is high.
- R11: With the count at zero, a high `dev_req` does not raise `bus_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe from the processor |
| cfg_sel | input | 1 | Register select: 0 start address, 1 word count |
| cfg_wdata | input | CFG_W | Register write data |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | Acknowledge to the peripheral, high while it is being served |
| bus_hold | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | ADDR_W | Memory address of the current word, zero when not driving |
| mem_addr_oe | output | 1 | Address bus drive enable |
| io_rd | output | 1 | Peripheral read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc_done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The assertions assume that the processor keeps `hold_ack` high from the grant until `bus_hold` falls. They also assume it never grants the bus while no request is pending. The bench models the processor so that it raises the grant only after a chosen delay while `bus_hold` is high, and drops it as soon as `bus_hold` is low. The bench drives register writes and request changes only between edges. Every burst it starts is allowed to finish or pause within the observed window.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_HOLD,
    ST_ACK,
    ST_XFER,
    ST_RELEASE
  } dma_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              lock,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cnt_zero,
  output logic              cnt_last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cnt_q    <= '0;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      cnt_q    <= cnt_q - 1'b1;
    end else if (cfg_we && !lock) begin
      if (cfg_sel) cnt_q    <= cfg_wdata[CNT_W-1:0];
      else         cur_addr <= cfg_wdata[ADDR_W-1:0];
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_W'(1));

  // R6: one word advances address and count by one each
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)) &&
             (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  // R10: locked writes leave both registers untouched
  assert_cfg_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && cfg_we && !step) |=> (cur_addr == $past(cur_addr)) && (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req,
  input  logic hold_ack,
  input  logic cnt_zero,
  input  logic cnt_last,
  output logic bus_hold,
  output logic dev_ack,
  output logic xfer,
  output logic tc_done
);
  dma_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (dev_req && !cnt_zero) state_nx = ST_REQ_HOLD;
      ST_REQ_HOLD: if (hold_ack)             state_nx = ST_ACK;
      ST_ACK:                                state_nx = ST_XFER;
      ST_XFER:     if (cnt_last || !dev_req) state_nx = ST_RELEASE;
      ST_RELEASE:                            state_nx = ST_IDLE;
      default:                               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tc_done <= 1'b0;
    end else begin
      state   <= state_nx;
      tc_done <= (state == ST_XFER) && cnt_last;
    end
  end

  assign bus_hold = (state == ST_REQ_HOLD) || (state == ST_ACK) || (state == ST_XFER);
  assign dev_ack  = (state == ST_ACK) || (state == ST_XFER);
  assign xfer     = (state == ST_XFER);

  // R3: no acknowledge phase without a sampled grant
  assert_grant_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ_HOLD && !hold_ack) |=> (state == ST_REQ_HOLD));

  // R2: bus request never drops before the transfer phase
  assert_hold_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hold && !xfer) |=> bus_hold);

  // R7: completion pulse lasts one cycle and comes with the bus released
  assert_tc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_done |=> !tc_done);
  assert_tc_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_done |-> !bus_hold && !dev_ack);

  // R9: a released bus stays released for at least one more cycle
  assert_hold_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hold) |=> !bus_hold);

  // R11: empty count never starts a bus request
  assert_zero_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cnt_zero) |=> !bus_hold);
endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              bus_hold,
  input  logic              hold_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_oe,
  output logic              io_rd,
  output logic              mem_wr,
  output logic              tc_done
);
  logic [ADDR_W-1:0] cur_addr;
  logic cnt_zero, cnt_last, xfer;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .lock(bus_hold), .step(xfer),
    .cur_addr(cur_addr), .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  dma_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .hold_ack(hold_ack),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last), .bus_hold(bus_hold),
    .dev_ack(dev_ack), .xfer(xfer), .tc_done(tc_done)
  );

  assign mem_addr_oe = xfer;
  assign mem_addr    = xfer ? cur_addr : '0;
  assign io_rd       = xfer;
  assign mem_wr      = xfer;

  // R5: a strobed word always has the address driven and the peripheral acknowledged
  assert_word_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> mem_wr && mem_addr_oe && dev_ack && bus_hold);
endmodule

// File: tb/dma_flyby_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_flyby_ctrl_tb_top;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic dev_req = 1'b0, hold_ack = 1'b0;
  logic dev_ack, bus_hold, mem_addr_oe, io_rd, mem_wr, tc_done;
  logic [AW-1:0] mem_addr;

  int checks = 0, failures = 0;
  int grant_delay = 0, gcnt = 0;
  int words, tc_cnt, tc_words, tc_wide, ack_cyc, hold_rises;
  int viol_grant, viol_pair, viol_hold, viol_tc;
  int low_run, min_gap, sess_words;
  logic prev_hold, prev_tc, seen_high;
  logic [AW-1:0] addr_log [0:15];

  always #5 clk = ~clk;

  dma_flyby_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .bus_hold(bus_hold), .hold_ack(hold_ack), .mem_addr(mem_addr),
    .mem_addr_oe(mem_addr_oe), .io_rd(io_rd), .mem_wr(mem_wr), .tc_done(tc_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    words = 0; tc_cnt = 0; tc_words = -1; tc_wide = 0; ack_cyc = 0; hold_rises = 0;
    viol_grant = 0; viol_pair = 0; viol_hold = 0; viol_tc = 0;
    low_run = 0; min_gap = 99; sess_words = 0;
    prev_hold = bus_hold; prev_tc = 1'b0; seen_high = 1'b0;
  endtask

  // one cycle: sample outputs between edges, then update the processor model
  task automatic cyc();
    @(negedge clk);
    if ((dev_ack || io_rd || mem_wr || mem_addr_oe) && !hold_ack) viol_grant++;
    if ((io_rd != mem_wr) || (io_rd && !mem_addr_oe) || (io_rd && !dev_ack) ||
        (!mem_addr_oe && mem_addr != '0)) viol_pair++;
    if (dev_ack) ack_cyc++;
    if (io_rd) begin
      if (words < 16) addr_log[words] = mem_addr;
      words++;
      sess_words++;
    end
    if (tc_done) begin
      tc_cnt++;
      tc_words = words;
      if (prev_tc) tc_wide++;
      if (bus_hold || dev_ack || io_rd) viol_tc++;
    end
    if (!bus_hold) begin
      if (prev_hold && sess_words == 0) viol_hold++;
      low_run++;
    end else begin
      if (!prev_hold) begin
        hold_rises++;
        if (seen_high && low_run < min_gap) min_gap = low_run;
        sess_words = 0;
      end
      seen_high = 1'b1;
      low_run = 0;
    end
    prev_hold = bus_hold;
    prev_tc = tc_done;
    if (!bus_hold) begin
      hold_ack = 1'b0;
      gcnt = 0;
    end else if (gcnt >= grant_delay) begin
      hold_ack = 1'b1;
    end else begin
      gcnt++;
    end
  endtask

  task automatic prog(input logic sel, input logic [AW-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    check(!bus_hold && !dev_ack && !io_rd && !mem_wr && !mem_addr_oe && !tc_done,
          "R1", "control outputs after reset", int'(bus_hold | dev_ack | io_rd | tc_done), 0);
    check(mem_addr == '0, "R1", "mem_addr after reset", int'(mem_addr), 0);
  endtask

  task automatic t_basic();
    prog(1'b0, 16'h0100);
    prog(1'b1, 16'd3);
    grant_delay = 2;
    clear_mon();
    dev_req = 1'b1;
    cyc();
    check(bus_hold == 1'b1, "R2", "hold one cycle after request", int'(bus_hold), 1);
    repeat (20) cyc();
    dev_req = 1'b0;
    check(words == 3, "R6", "words moved", words, 3);
    for (int i = 0; i < 3; i++)
      check(addr_log[i] == 16'h0100 + 16'(i), "R6", "word address", int'(addr_log[i]), 16'h0100 + i);
    check(viol_grant == 0, "R3", "bus activity before grant", viol_grant, 0);
    check(viol_pair == 0, "R5", "strobe/address framing errors", viol_pair, 0);
    check(ack_cyc == 4, "R4", "acknowledge cycles", ack_cyc, 4);
    check(viol_hold == 0, "R2", "hold dropped before any word", viol_hold, 0);
    check(hold_rises == 1, "R2", "hold requests in burst", hold_rises, 1);
    check(tc_cnt == 1 && tc_wide == 0, "R7", "completion pulses", tc_cnt, 1);
    check(tc_words == 3 && viol_tc == 0, "R7", "words before completion", tc_words, 3);
  endtask

  task automatic t_pause();
    prog(1'b0, 16'h0200);
    prog(1'b1, 16'd5);
    grant_delay = 0;
    clear_mon();
    dev_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (words == 2) dev_req = 1'b0;
    end
    check(words == 2, "R8", "words before pause", words, 2);
    check(tc_cnt == 0, "R8", "no completion on pause", tc_cnt, 0);
    check(bus_hold == 1'b0, "R8", "bus released on pause", int'(bus_hold), 0);
    clear_mon();
    dev_req = 1'b1;
    repeat (20) cyc();
    dev_req = 1'b0;
    check(words == 3, "R8", "words after resume", words, 3);
    for (int i = 0; i < 3; i++)
      check(addr_log[i] == 16'h0202 + 16'(i), "R8", "resumed address", int'(addr_log[i]), 16'h0202 + i);
    check(tc_cnt == 1, "R8", "completion after resume", tc_cnt, 1);
  endtask

  task automatic t_gap();
    bit dropped = 1'b0;
    prog(1'b0, 16'h0040);
    prog(1'b1, 16'd4);
    grant_delay = 1;
    clear_mon();
    dev_req = 1'b1;
    for (int i = 0; i < 30; i++) begin
      cyc();
      if (words == 1 && !dropped) begin
        dropped = 1'b1;
        dev_req = 1'b0;
        cyc();
        dev_req = 1'b1;
      end
    end
    dev_req = 1'b0;
    check(hold_rises == 2, "R9", "hold requests around pause", hold_rises, 2);
    check(min_gap >= 1, "R9", "hold low cycles between requests", min_gap, 1);
    check(words == 4 && tc_cnt == 1, "R9", "words after quick re-request", words, 4);
  endtask

  task automatic t_lock();
    prog(1'b0, 16'h0300);
    prog(1'b1, 16'd2);
    grant_delay = 3;
    clear_mon();
    dev_req = 1'b1;
    for (int i = 0; i < 5 && !bus_hold; i++) cyc();
    prog(1'b0, 16'hBEEF);
    prog(1'b1, 16'd9);
    repeat (15) cyc();
    dev_req = 1'b0;
    check(words == 2, "R10", "words despite locked count write", words, 2);
    check(addr_log[0] == 16'h0300 && addr_log[1] == 16'h0301, "R10",
          "addresses despite locked write", int'(addr_log[0]), 16'h0300);
    check(tc_cnt == 1, "R10", "completion despite locked write", tc_cnt, 1);
  endtask

  task automatic t_zero();
    prog(1'b1, 16'd0);
    clear_mon();
    dev_req = 1'b1;
    repeat (10) cyc();
    check(hold_rises == 0 && words == 0, "R11", "hold with empty count", hold_rises, 0);
    prog(1'b0, 16'h0500);
    prog(1'b1, 16'd1);
    repeat (12) cyc();
    dev_req = 1'b0;
    check(words == 1 && addr_log[0] == 16'h0500, "R11", "single word after reload", words, 1);
    check(tc_cnt == 1 && tc_wide == 0, "R7", "completion for count of one", tc_cnt, 1);
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_basic();
    t_pause();
    t_gap();
    t_lock();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule